// File: doc/BRIEF.md
# Port Pin Wake-Up Comparator

This block watches a small general-purpose input port while the device is stopped and produces a wake-up event. Software chooses which pins take part through an enable register, and only pins that the direction register marks as inputs can contribute. The pins pass through a two-flop synchronizer before any comparison.

The block has two kinds of wake rule. In the default rule, any participating pin at a low level causes a wake. Once at least one pin is enabled, each access to the port data register captures a fresh per-pin reference for the enabled pins. A read captures the synchronized pin levels. A write captures the written data. After such a capture, the rule becomes "wake when any participating pin differs from its reference". A two-bit status code records whether the last capture came from a read or a write. Software writes zero to that code to return to the default low-level rule.

The wake output is a single-cycle pulse. It fires on the first cycle in which the stop-mode flag is high and a mismatch is present.

Top module: `portwake_top`

## Requirements
- R1: After reset the enable register is 00, the direction register is FF (1 = input), the status code is 00, every reference bit is 0 and wake_pulse is low.
- R2: Register addresses are: 0 = port data (a read returns the synchronized pin levels), 1 = direction, 2 = enable, 3 = status (bits [1:0] hold the code, the upper bits read 0). Read data appears on bus_rdata one clock after the read strobe.
- R3: With status code 00, a wake occurs when any pin that is enabled and set as an input is at level 0.
- R4: A port data read while any enable bit is set copies the synchronized pin levels into the reference bits of the enabled pins and sets the status code to 01.
- R5: A port data write while any enable bit is set copies bus_wdata into the reference bits of the enabled pins and sets the status code to 10.
- R6: With status code 01 or 10, a wake occurs when any pin that is enabled and set as an input differs from its reference bit.
- R7: Writing a value with bits [1:0] = 00 to the status register sets the code to 00. Writing any other value to the status register leaves the code unchanged.
- R8: If a port data read and a port data write occur in the same cycle, the write sets both the reference and the code (code 10).
- R9: A port data access while every enable bit is 0 changes neither the reference nor the status code.
- R10: A pin that is disabled, or set as an output (direction bit 0), never contributes to a wake in any mode.
- R11: wake_pulse is high for exactly one cycle when the condition "stop_mode high and a mismatch present" first becomes true. It is never high because of a mismatch seen while stop_mode is low.
- R12: Captures leave the reference bits of disabled pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Registered read data |
| pin_in | input | PINS | Asynchronous port pin levels |
| stop_mode | input | 1 | High while the device is stopped |
| wake_pulse | output | 1 | One-cycle wake-up event |

## Verification
On every cycle, assertions check the following:
- The status code that follows a capturing port read or write (R4, R5).
- That the reference stays still when no pin is enabled (R9).
- That the reference bits of disabled pins stay unchanged (R12).
- That non-zero status writes are ignored (R7).
- That the wake pulse lasts one cycle and only follows a cycle with stop_mode high (R11).

Only the bench scenarios can show that the wake decision is right. It sweeps every pin pattern against several enable, direction and reference settings, in the low-level rule and in both reference rules. It also covers the priority of a write over a read in the same cycle, and the return to the default rule after a status clear.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_READ  = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_RSVD  = 2'b11
  } wake_mode_e;

  localparam int          ADDR_W    = 2;
  localparam logic [1:0]  ADDR_PORT = 2'd0;
  localparam logic [1:0]  ADDR_DIR  = 2'd1;
  localparam logic [1:0]  ADDR_ENA  = 2'd2;
  localparam logic [1:0]  ADDR_STAT = 2'd3;
endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwk_regs.sv
module pwk_regs
  import pwk_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PINS-1:0]   wdata_i,
  input  logic [PINS-1:0]   pins_i,
  output logic [PINS-1:0]   en_o,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   ref_o,
  output wake_mode_e        mode_o,
  output logic [PINS-1:0]   rdata_o
);
  localparam int PAD = PINS - 2;

  logic [PINS-1:0] en_q, dir_q, ref_q, ref_d;
  wake_mode_e      mode_q;
  logic            port_rd, port_wr, any_en, stat_clr;

  assign port_rd  = rd_i && (addr_i == ADDR_PORT);
  assign port_wr  = wr_i && (addr_i == ADDR_PORT);
  assign any_en   = |en_q;
  assign stat_clr = wr_i && (addr_i == ADDR_STAT) && (wdata_i[1:0] == 2'b00);

  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_ref
      assign ref_d[g] = !en_q[g] ? ref_q[g] :
                        port_wr  ? wdata_i[g] :
                        port_rd  ? pins_i[g] : ref_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      dir_q  <= '1;
      ref_q  <= '0;
      mode_q <= MODE_LEVEL;
    end else begin
      ref_q <= ref_d;
      if (wr_i && addr_i == ADDR_ENA) en_q  <= wdata_i;
      if (wr_i && addr_i == ADDR_DIR) dir_q <= wdata_i;
      if (any_en && port_wr)      mode_q <= MODE_WRITE;
      else if (any_en && port_rd) mode_q <= MODE_READ;
      else if (stat_clr)          mode_q <= MODE_LEVEL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (addr_i)
        ADDR_PORT: rdata_o <= pins_i;
        ADDR_DIR:  rdata_o <= dir_q;
        ADDR_ENA:  rdata_o <= en_q;
        default:   rdata_o <= {{PAD{1'b0}}, mode_q};
      endcase
    end
  end

  assign en_o   = en_q;
  assign dir_o  = dir_q;
  assign ref_o  = ref_q;
  assign mode_o = mode_q;

  // R5
  wr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (port_wr && any_en) |=> (mode_q == MODE_WRITE));
  // R4
  rd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && !port_wr && any_en) |=> (mode_q == MODE_READ));
  // R9
  idle_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_en) |=> $stable(ref_q));
  // R12
  keep_ref_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((ref_q ^ $past(ref_q)) & ~$past(en_q)) == '0));
  // R7
  stat_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_STAT && wdata_i[1:0] != 2'b00) |=> $stable(mode_q));
endmodule

// File: rtl/pwk_match.sv
module pwk_match
  import pwk_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] pins_i,
  input  logic [PINS-1:0] en_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] ref_i,
  input  wake_mode_e      mode_i,
  output logic            any_o
);
  logic [PINS-1:0] miss;
  logic            level_rule;

  assign level_rule = (mode_i == MODE_LEVEL);

  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_pin
      assign miss[g] = en_i[g] & dir_i[g] &
                       (level_rule ? ~pins_i[g] : (pins_i[g] ^ ref_i[g]));
    end
  endgenerate

  assign any_o = |miss;
endmodule

// File: rtl/pwk_pulse.sv
module pwk_pulse (
  input  logic clk,
  input  logic rst,
  input  logic stop_i,
  input  logic hit_i,
  output logic wake_o
);
  logic armed_q, wake_q, fire;

  assign fire = stop_i & hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      armed_q <= fire;
      wake_q  <= fire & ~armed_q;
    end
  end

  assign wake_o = wake_q;

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
  // R11
  stop_only_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> $past(stop_i));
endmodule

// File: rtl/portwake_top.sv
module portwake_top
  import pwk_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic              stop_mode,
  output logic              wake_pulse
);
  logic [PINS-1:0] pins_s, en, dir, refv;
  wake_mode_e      mode;
  logic            hit;

  pwk_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_in), .q_o(pins_s)
  );

  pwk_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst(rst), .rd_i(bus_rd), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pins_i(pins_s), .en_o(en), .dir_o(dir),
    .ref_o(refv), .mode_o(mode), .rdata_o(bus_rdata)
  );

  pwk_match #(.PINS(PINS)) u_match (
    .pins_i(pins_s), .en_i(en), .dir_i(dir), .ref_i(refv),
    .mode_i(mode), .any_o(hit)
  );

  pwk_pulse u_pulse (
    .clk(clk), .rst(rst), .stop_i(stop_mode), .hit_i(hit), .wake_o(wake_pulse)
  );
endmodule

// File: tb/sim_portwake_top.sv
module sim_portwake_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic       stop_mode = 1'b0;
  logic       wake_pulse;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  portwake_top #(.PINS(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .stop_mode(stop_mode), .wake_pulse(wake_pulse)
  );

  always @(negedge clk) if (wake_pulse) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle_pins(input logic [7:0] p);
    @(negedge clk); pin_in = p;
    repeat (4) @(negedge clk);
  endtask

  // Applies pattern p with stop low, then raises stop; returns pulses seen.
  task automatic run_stop(input logic [7:0] p, output int pre, output int n);
    pulses = 0;
    settle_pins(p);
    pre = pulses;
    stop_mode = 1'b1;
    repeat (5) @(negedge clk);
    stop_mode = 1'b0;
    repeat (2) @(negedge clk);
    n = pulses - pre;
  endtask

  function automatic int exp_level(logic [7:0] p, logic [7:0] en, logic [7:0] dir);
    return (|(~p & en & dir)) ? 1 : 0;
  endfunction

  function automatic int exp_ref(logic [7:0] p, logic [7:0] r, logic [7:0] en, logic [7:0] dir);
    return (|((p ^ r) & en & dir)) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int pre, n;
    logic [7:0] en_set [2] = '{8'hFF, 8'hA5};
    logic [7:0] dir_set[2] = '{8'hFF, 8'hF0};
    logic [7:0] r_set  [3] = '{8'h00, 8'hFF, 8'h5A};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R2 register map
    chk("R1 wake", wake_pulse, 0);
    rd_reg(2'd2, d); chk("R1 enable", d, 8'h00);
    rd_reg(2'd1, d); chk("R1 direction", d, 8'hFF);
    rd_reg(2'd3, d); chk("R1 status", d, 8'h00);
    wr_reg(2'd1, 8'h3C); rd_reg(2'd1, d); chk("R2 direction readback", d, 8'h3C);

    // R3 / R10 default low-level rule, exhaustive pin sweep
    for (int ei = 0; ei < 2; ei++) begin
      for (int di = 0; di < 2; di++) begin
        wr_reg(2'd2, en_set[ei]);
        wr_reg(2'd1, dir_set[di]);
        for (int p = 0; p < 256; p++) begin
          run_stop(8'(p), pre, n);
          chk("R3 R10 level rule", n, exp_level(8'(p), en_set[ei], dir_set[di]));
          if (p == 0) chk("R11 no wake while stop low", pre, 0);
        end
      end
    end

    // R4 / R6 read reference
    for (int ei = 0; ei < 2; ei++) begin
      for (int ri = 0; ri < 3; ri++) begin
        wr_reg(2'd2, en_set[ei]);
        wr_reg(2'd1, dir_set[ei]);
        settle_pins(r_set[ri]);
        rd_reg(2'd0, d); chk("R2 port read", d, r_set[ri]);
        rd_reg(2'd3, d); chk("R4 status after read", d, 8'h01);
        for (int p = 0; p < 256; p++) begin
          run_stop(8'(p), pre, n);
          chk("R6 read ref rule", n, exp_ref(8'(p), r_set[ri], en_set[ei], dir_set[ei]));
        end
      end
    end

    // R5 / R6 write reference
    for (int ei = 0; ei < 2; ei++) begin
      for (int ri = 0; ri < 3; ri++) begin
        wr_reg(2'd2, en_set[ei]);
        wr_reg(2'd1, dir_set[ei]);
        wr_reg(2'd0, r_set[ri] ^ 8'h3C);
        rd_reg(2'd3, d); chk("R5 status after write", d, 8'h02);
        for (int p = 0; p < 256; p++) begin
          run_stop(8'(p), pre, n);
          chk("R6 write ref rule", n, exp_ref(8'(p), r_set[ri] ^ 8'h3C, en_set[ei], dir_set[ei]));
        end
      end
    end

    // R12 disabled reference bits kept
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd2, 8'hFF); wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h01); wr_reg(2'd0, 8'hFF);
    wr_reg(2'd2, 8'hFF);
    run_stop(8'hFF, pre, n); chk("R12 disabled bits kept (mismatch)", n, 1);
    run_stop(8'h01, pre, n); chk("R12 disabled bits kept (match)", n, 0);

    // R9 accesses with no enable
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'hAA);
    settle_pins(8'h55);
    rd_reg(2'd0, d);
    rd_reg(2'd3, d); chk("R9 status unchanged", d, 8'h02);
    wr_reg(2'd2, 8'hFF);
    run_stop(8'h01, pre, n); chk("R9 reference unchanged", n, 0);

    // R7 status writes
    wr_reg(2'd3, 8'h01); rd_reg(2'd3, d); chk("R7 nonzero write ignored", d, 8'h02);
    wr_reg(2'd3, 8'hFC); rd_reg(2'd3, d); chk("R7 clear", d, 8'h00);
    run_stop(8'hFF, pre, n); chk("R7 default rule restored (high)", n, 0);
    run_stop(8'hFE, pre, n); chk("R7 default rule restored (low)", n, 1);

    // R8 simultaneous read and write
    settle_pins(8'h00);
    @(negedge clk); bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hFF;
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
    rd_reg(2'd3, d); chk("R8 write wins status", d, 8'h02);
    run_stop(8'hFF, pre, n); chk("R8 write wins reference (match)", n, 0);
    run_stop(8'h00, pre, n); chk("R8 write wins reference (mismatch)", n, 1);

    // R11 persistent mismatch under long stop gives a single pulse
    pulses = 0;
    settle_pins(8'h00);
    stop_mode = 1'b1;
    repeat (40) @(negedge clk);
    stop_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 single pulse", pulses, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule